// File: doc/BRIEF.md
# Flag-Setting Data-Processing Execute Unit

This block is the execute stage for four data-processing operations of a 32-bit instruction set: addition, bitwise test, move and compare. Each cycle with `op_valid` high, it takes the opcode field, the set-flags bit, the destination index, the first operand value and the instruction word. The second operand is either an immediate built from the low twelve bits of the instruction word or a value from an external shifter. The unit returns the result for the register file on the same cycle. It holds the four condition flags (negative, zero, carry, overflow) in a register that changes at the next clock edge.

Each operation has its own flag rules. Compare and test never write a destination and always update flags. Addition and move update flags only when set-flags is on and the destination is not register 15. The carry for test and move comes from the shifter. A register-operand instruction that asks for flags with destination 15 is refused as illegal. Any other opcode is reported as unsupported. Refused, unsupported and idle cycles write nothing and leave the flags alone.

Top module: `dp_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the flag register clears, so after reset N, Z, C and V all read 0.
- R2: With `imm_sel` = 1, the second operand is `instr_word[7:0]`, zero-extended and rotated right by 2 × `instr_word[11:8]` bit positions.
- R3: With `imm_sel` = 0, the second operand is `shift_val`.
- R4: Opcode 4'h4 (add) drives `wr_data` = first operand + second operand modulo 2^32, with `wr_en` = 1.
- R5: For add with `set_flags` = 1 and `dst_idx` ≠ 15, the next flags are: N = result bit 31, Z = (result == 0), C = carry out of bit 31, and V = (a[31] == b[31]) && (r[31] != a[31]).
- R6: Opcode 4'hA (compare) keeps `wr_en` = 0 and always loads flags from a − b: N = bit 31, Z = zero, C = (b ≤ a unsigned), V = (a[31] != b[31]) && (r[31] != a[31]).
- R7: Opcode 4'h8 (test) keeps `wr_en` = 0 and always sets N and Z from a & b and C from `shift_carry`. V is left unchanged.
- R8: Opcode 4'hD (move) drives `wr_data` = second operand with `wr_en` = 1. With `set_flags` = 1 and `dst_idx` ≠ 15, it sets N and Z from that value and C from `shift_carry`, and leaves V unchanged.
- R9: Add and move with `set_flags` = 0, or with `dst_idx` = 15, leave all flags unchanged.
- R10: With `op_valid`, `imm_sel` = 0, `set_flags` = 1 and `dst_idx` = 15, `illegal` = 1 for any opcode; `wr_en` = 0 and the flags are unchanged.
- R11: Any opcode other than 4'h4, 4'h8, 4'hA or 4'hD sets `unsupported` = 1, with `wr_en` = 0 and the flags unchanged.
- R12: With `op_valid` = 0, `wr_en`, `illegal` and `unsupported` are 0 and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 4 | Operation select |
| imm_sel | input | 1 | 1: immediate second operand, 0: shifter value |
| set_flags | input | 1 | Request a flag update |
| dst_idx | input | 4 | Destination register index |
| src_a | input | 32 | First operand value |
| instr_word | input | 32 | Instruction word (immediate field in bits 11:0) |
| shift_val | input | 32 | Shifter result |
| shift_carry | input | 1 | Shifter carry out |
| wr_data | output | 32 | Destination write data |
| wr_en | output | 1 | Destination write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| illegal | output | 1 | Flag-setting register form with destination 15 |
| unsupported | output | 1 | Opcode not implemented |

## Verification
The assertions check, on every cycle, rules that hold whatever the operands are. Compare and test never write. A refused or idle cycle never writes and raises no indication. Unsupported opcodes and moves leave the flags, or V alone, as they were. The arithmetic can only be shown by the bench's directed and random scenarios, which compare the operand rotation, sums, differences, carry, overflow and zero detection against a reference model, including the wrap-around and sign-boundary cases.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;
    localparam int IMM_W    = 8;
    localparam int ROT_W    = 4;
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(15);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        OP_ADD = 4'h4,
        OP_TST = 4'h8,
        OP_CMP = 4'hA,
        OP_MOV = 4'hD
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic word_t expand_imm(input logic [IMM_W+ROT_W-1:0] field);
        word_t               base;
        logic [2*DATA_W-1:0] dbl;
        int unsigned         amt;
        base = word_t'(field[IMM_W-1:0]);
        amt  = 2 * int'(field[IMM_W+ROT_W-1:IMM_W]);
        dbl  = {base, base} >> amt;
        return dbl[DATA_W-1:0];
    endfunction

    function automatic logic is_known_op(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_TST) || (op == OP_CMP) || (op == OP_MOV);
    endfunction

endpackage

// File: rtl/dp_operand.sv
module dp_operand
    import dp_alu_pkg::*;
(
    input  logic  imm_sel,
    input  word_t instr_word,
    input  word_t shift_val,
    output word_t op_b
);
    localparam int FIELD_W = IMM_W + ROT_W;

    word_t imm_val;

    always_comb begin
        imm_val = expand_imm(instr_word[FIELD_W-1:0]);
        op_b    = imm_sel ? imm_val : shift_val;
    end
endmodule

// File: rtl/dp_exec.sv
module dp_exec
    import dp_alu_pkg::*;
(
    input  logic             op_valid,
    input  logic [3:0]       opcode,
    input  logic             imm_sel,
    input  logic             set_flags,
    input  logic [IDX_W-1:0] dst_idx,
    input  word_t            op_a,
    input  word_t            op_b,
    input  logic             shift_carry,
    input  flags_t           flags_cur,
    output word_t            wr_data,
    output logic             wr_en,
    output flags_t           flags_nxt,
    output logic             flags_upd,
    output logic             illegal,
    output logic             unsupported
);
    logic [DATA_W:0] sum_ext;
    logic [DATA_W:0] dif_ext;
    word_t           and_val;
    logic            blocked;
    logic            may_set;

    always_comb begin
        sum_ext = {1'b0, op_a} + {1'b0, op_b};
        dif_ext = {1'b0, op_a} - {1'b0, op_b};
        and_val = op_a & op_b;

        illegal     = op_valid && !imm_sel && set_flags && (dst_idx == PC_IDX);
        unsupported = op_valid && !is_known_op(opcode);
        blocked     = !op_valid || illegal || unsupported;
        may_set     = set_flags && (dst_idx != PC_IDX);

        wr_data   = '0;
        wr_en     = 1'b0;
        flags_nxt = flags_cur;
        flags_upd = 1'b0;

        if (!blocked) begin
            unique case (opcode)
                OP_ADD: begin
                    wr_data = sum_ext[DATA_W-1:0];
                    wr_en   = 1'b1;
                    if (may_set) begin
                        flags_upd   = 1'b1;
                        flags_nxt.n = sum_ext[DATA_W-1];
                        flags_nxt.z = (sum_ext[DATA_W-1:0] == '0);
                        flags_nxt.c = sum_ext[DATA_W];
                        flags_nxt.v = (op_a[DATA_W-1] == op_b[DATA_W-1]) &&
                                      (sum_ext[DATA_W-1] != op_a[DATA_W-1]);
                    end
                end
                OP_CMP: begin
                    flags_upd   = 1'b1;
                    flags_nxt.n = dif_ext[DATA_W-1];
                    flags_nxt.z = (dif_ext[DATA_W-1:0] == '0);
                    flags_nxt.c = !dif_ext[DATA_W];
                    flags_nxt.v = (op_a[DATA_W-1] != op_b[DATA_W-1]) &&
                                  (dif_ext[DATA_W-1] != op_a[DATA_W-1]);
                end
                OP_TST: begin
                    flags_upd   = 1'b1;
                    flags_nxt.n = and_val[DATA_W-1];
                    flags_nxt.z = (and_val == '0);
                    flags_nxt.c = shift_carry;
                end
                OP_MOV: begin
                    wr_data = op_b;
                    wr_en   = 1'b1;
                    if (may_set) begin
                        flags_upd   = 1'b1;
                        flags_nxt.n = op_b[DATA_W-1];
                        flags_nxt.z = (op_b == '0);
                        flags_nxt.c = shift_carry;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
    import dp_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (upd)
            q <= nxt;
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  opcode,
    input  logic        imm_sel,
    input  logic        set_flags,
    input  logic [3:0]  dst_idx,
    input  logic [31:0] src_a,
    input  logic [31:0] instr_word,
    input  logic [31:0] shift_val,
    input  logic        shift_carry,
    output logic [31:0] wr_data,
    output logic        wr_en,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c,
    output logic        flag_v,
    output logic        illegal,
    output logic        unsupported
);
    word_t  op_b;
    flags_t flags_q;
    flags_t flags_nxt;
    logic   flags_upd;

    dp_operand u_operand (
        .imm_sel    (imm_sel),
        .instr_word (instr_word),
        .shift_val  (shift_val),
        .op_b       (op_b)
    );

    dp_exec u_exec (
        .op_valid    (op_valid),
        .opcode      (opcode),
        .imm_sel     (imm_sel),
        .set_flags   (set_flags),
        .dst_idx     (dst_idx),
        .op_a        (src_a),
        .op_b        (op_b),
        .shift_carry (shift_carry),
        .flags_cur   (flags_q),
        .wr_data     (wr_data),
        .wr_en       (wr_en),
        .flags_nxt   (flags_nxt),
        .flags_upd   (flags_upd),
        .illegal     (illegal),
        .unsupported (unsupported)
    );

    dp_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .upd (flags_upd),
        .nxt (flags_nxt),
        .q   (flags_q)
    );

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // R6 R7
    cmp_tst_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (opcode == OP_CMP || opcode == OP_TST)) |-> !wr_en);

    // R10
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en);

    // R11
    unsup_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (unsupported && !wr_en) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    // R8
    mov_v_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OP_MOV) |=> $stable(flag_v));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!wr_en && !illegal && !unsupported));

    // R12
    idle_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
module dp_alu_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  opcode;
    logic        imm_sel;
    logic        set_flags;
    logic [3:0]  dst_idx;
    logic [31:0] src_a;
    logic [31:0] instr_word;
    logic [31:0] shift_val;
    logic        shift_carry;
    logic [31:0] wr_data;
    logic        wr_en;
    logic        flag_n, flag_z, flag_c, flag_v;
    logic        illegal;
    logic        unsupported;

    int total = 0;
    int bad   = 0;
    logic [3:0] mflags;
    string prev_tag;

    always #5 clk = ~clk;

    dp_alu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .imm_sel(imm_sel), .set_flags(set_flags), .dst_idx(dst_idx),
        .src_a(src_a), .instr_word(instr_word), .shift_val(shift_val),
        .shift_carry(shift_carry), .wr_data(wr_data), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .illegal(illegal), .unsupported(unsupported)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rot_right(input logic [31:0] x, input int r);
        if (r == 0) return x;
        return (x >> r) | (x << (32 - r));
    endfunction

    task automatic run_op(input logic v, input logic [3:0] op, input logic im,
                          input logic s, input logic [3:0] d, input logic [31:0] a,
                          input logic [31:0] iw, input logic [31:0] sv, input logic sc);
        logic [31:0] b, r;
        logic [32:0] wide;
        logic exp_we, exp_ill, exp_uns, known;
        logic [31:0] exp_wd;
        string tag;
        @(negedge clk);
        check({prev_tag, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mflags});
        op_valid = v; opcode = op; imm_sel = im; set_flags = s; dst_idx = d;
        src_a = a; instr_word = iw; shift_val = sv; shift_carry = sc;
        #1;
        b = im ? rot_right({24'd0, iw[7:0]}, 2 * int'(iw[11:8])) : sv;  // R2 R3
        known   = (op == 4'h4) || (op == 4'h8) || (op == 4'hA) || (op == 4'hD);
        exp_ill = v && !im && s && (d == 4'd15);
        exp_uns = v && !known;
        exp_we  = 1'b0;
        exp_wd  = 32'd0;
        tag     = "R12";
        if (exp_ill) tag = "R10";
        else if (exp_uns) tag = "R11";
        else if (v) begin
            case (op)
                4'h4: begin
                    tag = (s && d != 4'd15) ? "R5" : "R9";
                    wide = {1'b0, a} + {1'b0, b};
                    r = wide[31:0];
                    exp_we = 1'b1; exp_wd = r;
                    if (s && d != 4'd15)
                        mflags = {r[31], r == 0, wide[32], (a[31] == b[31]) && (r[31] != a[31])};
                end
                4'hA: begin
                    tag = "R6";
                    r = a - b;
                    mflags = {r[31], r == 0, b <= a, (a[31] != b[31]) && (r[31] != a[31])};
                end
                4'h8: begin
                    tag = "R7";
                    r = a & b;
                    mflags = {r[31], r == 0, sc, mflags[0]};
                end
                default: begin
                    tag = (s && d != 4'd15) ? "R8" : "R9";
                    exp_we = 1'b1; exp_wd = b;
                    if (s && d != 4'd15)
                        mflags = {b[31], b == 0, sc, mflags[0]};
                end
            endcase
        end
        check({tag, " wr_en"}, {31'd0, wr_en}, {31'd0, exp_we});
        if (exp_we) check({tag, (im ? " R2" : " R3"), " R4/R8 wr_data"}, wr_data, exp_wd);
        check({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_ill});
        check({tag, " unsupported"}, {31'd0, unsupported}, {31'd0, exp_uns});
        prev_tag = tag;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] ops[5];
        void'($urandom(1234));
        rst = 1'b1; op_valid = 0; opcode = 0; imm_sel = 0; set_flags = 0; dst_idx = 0;
        src_a = 0; instr_word = 0; shift_val = 0; shift_carry = 0;
        mflags = 4'b0; prev_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset value checked by the first step's flag comparison
        // R2: rotate 0xFF right by 4 -> 0xF000000F, MOV with flags
        run_op(1, 4'hD, 1, 1, 4'd1, 32'h0, 32'h0000_02FF, 32'h0, 1);
        // R4 R5: carry and zero
        run_op(1, 4'h4, 0, 1, 4'd2, 32'hFFFF_FFFF, 32'h0, 32'h1, 0);
        // R5: signed overflow
        run_op(1, 4'h4, 0, 1, 4'd2, 32'h7FFF_FFFF, 32'h0, 32'h1, 0);
        // R6: equal -> Z and C
        run_op(1, 4'hA, 0, 0, 4'd0, 32'd5, 32'h0, 32'd5, 0);
        // R6: overflow on subtract
        run_op(1, 4'hA, 1, 0, 4'd0, 32'h8000_0000, 32'h0000_0001, 32'h0, 0);
        // R6: borrow
        run_op(1, 4'hA, 0, 0, 4'd0, 32'd3, 32'h0, 32'd4, 0);
        // R7: zero AND, C from shifter
        run_op(1, 4'h8, 0, 0, 4'd0, 32'hF0, 32'h0, 32'h0F, 1);
        // R9: ADD flags with dst 15 (immediate form) ignored
        run_op(1, 4'h4, 1, 1, 4'd15, 32'h8000_0000, 32'h0000_0080, 32'h0, 0);
        // R9: MOV without set_flags
        run_op(1, 4'hD, 0, 0, 4'd3, 32'h0, 32'h0, 32'h0, 0);
        // R10: register form, flags, dst 15
        run_op(1, 4'hD, 0, 1, 4'd15, 32'h0, 32'h0, 32'h0, 0);
        run_op(1, 4'hA, 0, 1, 4'd15, 32'h1, 32'h0, 32'h2, 1);
        // R11: unsupported opcode
        run_op(1, 4'h3, 0, 1, 4'd1, 32'h0, 32'h0, 32'h0, 0);
        // R12: idle with CMP that would change flags
        run_op(0, 4'hA, 0, 1, 4'd1, 32'd0, 32'h0, 32'd1, 0);
        ops = '{4'h4, 4'h8, 4'hA, 4'hD, 4'h0};
        for (int i = 0; i < 500; i++) begin
            logic [3:0] op, d;
            op = ops[$urandom_range(0, 4)];
            if (op == 4'h0) op = 4'($urandom);
            d = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom);
            run_op($urandom_range(0, 7) != 0, op, 1'($urandom), 1'($urandom), d,
                   ($urandom_range(0, 3) == 0) ? {1'($urandom), 31'd0} : $urandom,
                   $urandom, ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom, 1'($urandom));
        end
        @(negedge clk);
        check({prev_tag, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mflags});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule